// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a clocked host and an external asynchronous static RAM of 32K bytes. The host presents one request at a time: an address, a write flag and, for writes, a byte. The controller accepts it when it is idle. It then plays out the chip-select, write-enable and output-enable sequence that the memory needs. For a read, it returns the captured byte with a one-clock valid pulse.

All memory timing figures are parameters in nanoseconds. Each is converted to a whole number of clocks with a clock-period parameter, rounding up and never below one clock. Writes are shaped by write enable: chip select falls first, and the address and data stay put for the whole pulse. Reads are gated by output enable. The controller never turns its data drivers on until output enable has been high long enough for the memory to let go of the bus. The idle clock between operations keeps a gap between the controller driving the bus and the memory driving it.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and in the first idle clock after it, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, rd_valid is 0 and req_ready is 1.
- R2: A write holds mem_ce_n and mem_we_n at 0 for ceil(max(tWP,tDW)/tCLK) clocks (3 clocks at the defaults of 55 ns, 30 ns and 20 ns). During that time mem_oe_n is 1, mem_dq_oe is 1 and mem_dq_out carries the request byte.
- R3: After mem_we_n rises, the controller keeps mem_ce_n at 0 and mem_dq_oe at 1 for ceil(tDH/tCLK) clocks (1 at the defaults). mem_addr and mem_dq_out do not change while mem_ce_n stays low.
- R4: mem_dq_oe rises only after mem_oe_n has been 1 for ceil(tHZ/tCLK) clocks (2 at the defaults). A write accepted in the idle clock right after a read therefore spends one extra clock with mem_ce_n=0, mem_we_n=1, mem_oe_n=1 and drivers off before the pulse begins.
- R5: A read holds mem_ce_n and mem_oe_n at 0 and mem_we_n at 1 for max(ceil(tAA/tCLK), ceil(tOE/tCLK)) clocks (4 at the defaults). mem_dq_oe is 0 throughout that window and in the idle clock where the request is accepted.
- R6: The byte on mem_dq_in is captured at the clock edge that ends the read window. rd_valid is 1 for exactly the following clock, with rd_data holding that byte. All 15 address bits reach the memory, from 15'h0000 to 15'h7FFF.
- R7: req_ready is 1 only while idle. A request is taken at the rising edge where req_valid and req_ready are both 1. req_ready then stays 0 until the operation has lasted at least ceil(tWC/tCLK) or ceil(tRC/tCLK) clocks (4 at the defaults).
- R8: req_valid, req_write, req_addr and req_wdata are ignored while req_ready is 0. mem_addr and mem_dq_out keep the values of the accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-clock pulse: rd_data holds a read result |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 15 | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_in | input | 8 | Byte read from the data bus |
| mem_dq_oe | output | 1 | Enables the controller's data bus drivers |

## Verification
The embedded assertions are evaluated on every clock edge and cover the following rules:
- write enable is low only under chip select, with output enable high;
- the drivers never overlap output enable and come on only after the quiet count;
- the address and write data hold still while the chip is selected;
- the write pulse is never shorter than its clock count;
- rd_valid never lasts two clocks;
- the strobes are all high whenever ready is high.

Only the bench's scenarios show the rest:
- the exact clock count of each phase;
- that bytes written through the bus come back at the right full address;
- the extra turnaround clock when a write directly follows a read;
- that the request inputs are ignored while busy;
- a reset that lands in the middle of a write pulse.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_WTURN  = 3'd1,
      ST_WPULSE = 3'd2,
      ST_WHOLD  = 3'd3,
      ST_RACC   = 3'd4,
      ST_DONE   = 3'd5
   } sram_st_t;

   // Nanoseconds to whole clocks, rounded up, at least one clock.
   function automatic int ns_to_clk(input int t_ns, input int clk_ns);
      int c;
      c = (t_ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
   import sram_ctl_pkg::*;
#(
   parameter int WPUL_CLK = 3,
   parameter int DH_CLK   = 1,
   parameter int RD_CLK   = 4,
   parameter int WC_CLK   = 4,
   parameter int RC_CLK   = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_valid,
   input  logic     req_write,
   input  logic     oe_quiet,
   output sram_st_t st,
   output logic     accept,
   output logic     rd_last
);

   localparam int PH_MAX = imax(imax(WPUL_CLK, DH_CLK), RD_CLK);
   localparam int PH_W   = $clog2(PH_MAX + 1);
   localparam int EL_MAX = imax(WC_CLK, RC_CLK);
   localparam int EL_W   = $clog2(EL_MAX + 1);

   sram_st_t        st_nx;
   logic [PH_W-1:0] ph_cnt;
   logic [PH_W-1:0] ph_lim;
   logic [EL_W-1:0] el_cnt;
   logic            is_wr;
   logic            ph_last;
   logic            min_met;
   logic            ph_clr;

   assign accept = (st == ST_IDLE) && req_valid;

   always_comb begin
      ph_lim = PH_W'(1);
      case (st)
         ST_WPULSE: ph_lim = PH_W'(WPUL_CLK);
         ST_WHOLD:  ph_lim = PH_W'(DH_CLK);
         ST_RACC:   ph_lim = PH_W'(RD_CLK);
         default:   ph_lim = PH_W'(1);
      endcase
   end

   assign ph_last = (ph_cnt == (ph_lim - PH_W'(1)));
   assign min_met = is_wr ? (el_cnt >= EL_W'(WC_CLK - 1))
                          : (el_cnt >= EL_W'(RC_CLK - 1));
   assign rd_last = (st == ST_RACC) && ph_last;

   always_comb begin
      st_nx  = st;
      ph_clr = 1'b0;
      case (st)
         ST_IDLE: begin
            ph_clr = 1'b1;
            if (req_valid) begin
               if (!req_write)    st_nx = ST_RACC;
               else if (oe_quiet) st_nx = ST_WPULSE;
               else               st_nx = ST_WTURN;
            end
         end
         ST_WTURN: begin
            ph_clr = 1'b1;
            if (oe_quiet) st_nx = ST_WPULSE;
         end
         ST_WPULSE: begin
            if (ph_last) begin
               st_nx  = ST_WHOLD;
               ph_clr = 1'b1;
            end
         end
         ST_WHOLD, ST_RACC: begin
            if (ph_last) begin
               st_nx  = min_met ? ST_IDLE : ST_DONE;
               ph_clr = 1'b1;
            end
         end
         ST_DONE: begin
            ph_clr = 1'b1;
            if (min_met) st_nx = ST_IDLE;
         end
         default: begin
            st_nx  = ST_IDLE;
            ph_clr = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ph_cnt <= '0;
         el_cnt <= '0;
         is_wr  <= 1'b0;
      end else begin
         st     <= st_nx;
         ph_cnt <= ph_clr ? '0 : ph_cnt + PH_W'(1);
         if (accept) begin
            el_cnt <= '0;
            is_wr  <= req_write;
         end else if (st != ST_IDLE && el_cnt != EL_W'(EL_MAX)) begin
            el_cnt <= el_cnt + EL_W'(1);
         end
      end
   end

   AST_DONE_ONLY_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DONE) |-> !min_met || $past(st != ST_DONE)) else $error("early done hold");  // R7
   AST_WR_LEAVES_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WTURN && oe_quiet) |=> (st == ST_WPULSE)) else $error("turn stuck");  // R4

endmodule

// File: rtl/sram_ctl_strobe.sv
module sram_ctl_strobe
   import sram_ctl_pkg::*;
#(
   parameter int HZ_CLK   = 2,
   parameter int WPUL_CLK = 3
) (
   input  logic     clk,
   input  logic     rst_n,
   input  sram_st_t st,
   output logic     mem_ce_n,
   output logic     mem_we_n,
   output logic     mem_oe_n,
   output logic     mem_dq_oe,
   output logic     oe_quiet
);

   localparam int WL_W = $clog2(WPUL_CLK + 1);

   assign mem_ce_n  = !(st == ST_WTURN || st == ST_WPULSE ||
                        st == ST_WHOLD || st == ST_RACC);
   assign mem_we_n  = (st != ST_WPULSE);
   assign mem_oe_n  = (st != ST_RACC);
   assign mem_dq_oe = (st == ST_WPULSE) || (st == ST_WHOLD);

   generate
      if (HZ_CLK <= 1) begin : g_quiet_direct
         // One idle clock with output enable high already covers the release time.
         assign oe_quiet = 1'b1;
         AST_DRV_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mem_dq_oe) |-> $past(mem_oe_n)) else $error("drive too soon");  // R4
      end else begin : g_quiet_count
         localparam int HC_W = $clog2(HZ_CLK + 1);
         logic [HC_W-1:0] oe_hi_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               oe_hi_cnt <= HC_W'(HZ_CLK);
            else if (!mem_oe_n)
               oe_hi_cnt <= '0;
            else if (oe_hi_cnt != HC_W'(HZ_CLK))
               oe_hi_cnt <= oe_hi_cnt + HC_W'(1);
         end
         // This clock has output enable high, so it counts toward the release time.
         assign oe_quiet = (oe_hi_cnt >= HC_W'(HZ_CLK - 1));
         AST_DRV_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            mem_dq_oe |-> (oe_hi_cnt >= HC_W'(HZ_CLK))) else $error("drive too soon");  // R4
      end
   endgenerate

   // Checker-side count of consecutive write-enable-low clocks.
   logic [WL_W-1:0] we_lo_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         we_lo_cnt <= '0;
      else if (mem_we_n)
         we_lo_cnt <= '0;
      else if (we_lo_cnt != WL_W'(WPUL_CLK))
         we_lo_cnt <= we_lo_cnt + WL_W'(1);
   end

   AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_ce_n) else $error("we without ce");  // R2
   AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n) else $error("oe low in write");  // R2
   AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_lo_cnt >= WL_W'(WPUL_CLK))) else $error("short pulse");  // R2
   AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe) else $error("bus contention");  // R5

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              rd_last,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
      end else if (accept) begin
         mem_addr   <= req_addr;
         mem_dq_out <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_last;
         if (rd_last) rd_data <= mem_dq_in;
      end
   end

   AST_RDV_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid) else $error("rd_valid too long");  // R6
   AST_RDDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_last) |-> $stable(rd_data)) else $error("rd_data moved");  // R6

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W  = 15,
   parameter int DATA_W  = 8,
   parameter int CLK_NS  = 20,
   parameter int T_WC_NS = 70,
   parameter int T_WP_NS = 55,
   parameter int T_DW_NS = 30,
   parameter int T_DH_NS = 5,
   parameter int T_RC_NS = 70,
   parameter int T_AA_NS = 70,
   parameter int T_OE_NS = 35,
   parameter int T_HZ_NS = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   localparam int WPUL_CLK = imax(ns_to_clk(T_WP_NS, CLK_NS), ns_to_clk(T_DW_NS, CLK_NS));
   localparam int DH_CLK   = ns_to_clk(T_DH_NS, CLK_NS);
   localparam int RD_CLK   = imax(ns_to_clk(T_AA_NS, CLK_NS), ns_to_clk(T_OE_NS, CLK_NS));
   localparam int WC_CLK   = ns_to_clk(T_WC_NS, CLK_NS);
   localparam int RC_CLK   = ns_to_clk(T_RC_NS, CLK_NS);
   localparam int HZ_CLK   = ns_to_clk(T_HZ_NS, CLK_NS);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_ctl: address and data widths must be positive");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("sram_ctl: clock period must be at least 1 ns");
      end
      if (T_WP_NS < 0 || T_DW_NS < 0 || T_DH_NS < 0 || T_AA_NS < 0 ||
          T_OE_NS < 0 || T_HZ_NS < 0 || T_WC_NS < 0 || T_RC_NS < 0) begin : g_bad_time
         $error("sram_ctl: timing values must not be negative");
      end
   endgenerate

   sram_st_t st;
   logic     accept;
   logic     rd_last;
   logic     oe_quiet;

   sram_ctl_fsm #(
      .WPUL_CLK(WPUL_CLK), .DH_CLK(DH_CLK), .RD_CLK(RD_CLK),
      .WC_CLK(WC_CLK), .RC_CLK(RC_CLK)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .oe_quiet(oe_quiet), .st(st), .accept(accept), .rd_last(rd_last)
   );

   sram_ctl_strobe #(.HZ_CLK(HZ_CLK), .WPUL_CLK(WPUL_CLK)) u_strobe (
      .clk(clk), .rst_n(rst_n), .st(st), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe), .oe_quiet(oe_quiet)
   );

   sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
      .clk(clk), .rst_n(rst_n), .accept(accept), .rd_last(rd_last),
      .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .rd_valid(rd_valid),
      .rd_data(rd_data)
   );

   assign req_ready = (st == ST_IDLE);

   AST_IDLE_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)) else $error("idle strobes");  // R7
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)) else $error("address moved");  // R3
   AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)) else $error("write data moved");  // R3
   AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !$past(req_ready)) |-> $stable(mem_addr)) else $error("busy request taken");  // R8

endmodule

// File: tb/sim_sram_ctl.sv
module sim_sram_ctl;

   function automatic int cdiv(input int n, input int d);
      int q;
      q = (n + d - 1) / d;
      return (q < 1) ? 1 : q;
   endfunction

   localparam int TCLK  = 20;
   localparam int WP_C  = (cdiv(55, TCLK) > cdiv(30, TCLK)) ? cdiv(55, TCLK) : cdiv(30, TCLK);
   localparam int DH_C  = cdiv(5, TCLK);
   localparam int RD_C  = (cdiv(70, TCLK) > cdiv(35, TCLK)) ? cdiv(70, TCLK) : cdiv(35, TCLK);
   localparam int MIN_C = cdiv(70, TCLK);
   localparam int HZ_C  = cdiv(30, TCLK);

   // Entry bits: [25] noisy, [24] write, [22:8] address, [7:0] data or expected byte.
   localparam int NV = 12;
   localparam logic [31:0] VEC [NV] = '{
      32'h010000A5, 32'h017FFF3C, 32'h000000A5, 32'h01012300,
      32'h007FFF3C, 32'h00012300, 32'h030123FF, 32'h000123FF,
      32'h012AAA55, 32'h015555AA, 32'h022AAA55, 32'h005555AA
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic [14:0] mem_addr;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in;

   always #10 clk = ~clk;

   sram_ctl u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- small memory model ----------------
   logic [7:0]  mdat [256];
   logic [14:0] mtag [256];
   bit          mval [256];
   int          rd_run = 0;
   int          hz_run = 100;
   int          cont_err = 0;
   int          addr_err = 0;
   logic        p_ce = 1'b1, p_we = 1'b1, p_oe_drv = 1'b0;
   logic [7:0]  p_dq = '0;
   logic [14:0] p_ad = '0;

   initial for (int i = 0; i < 256; i++) mval[i] = 1'b0;

   wire m_read = !mem_ce_n && !mem_oe_n && mem_we_n;
   assign mem_dq_in = (rd_run >= RD_C && mval[mem_addr[7:0]] && mtag[mem_addr[7:0]] == mem_addr)
                      ? mdat[mem_addr[7:0]] : 8'hEE;

   always @(negedge clk) begin
      if (mem_dq_oe && (m_read || hz_run < HZ_C)) cont_err++;
      if (!p_ce && !p_we && !mem_ce_n && !mem_we_n && mem_addr != p_ad) addr_err++;
      if (!p_ce && !p_we && (mem_ce_n || mem_we_n)) begin
         mdat[p_ad[7:0]] = p_oe_drv ? p_dq : 8'hEE;
         mtag[p_ad[7:0]] = p_ad;
         mval[p_ad[7:0]] = 1'b1;
      end
      rd_run = m_read ? rd_run + 1 : 0;
      hz_run = m_read ? 0 : ((hz_run < 100) ? hz_run + 1 : hz_run);
      p_ce = mem_ce_n; p_we = mem_we_n; p_dq = mem_dq_out; p_ad = mem_addr; p_oe_drv = mem_dq_oe;
   end

   // ---------------- one host operation ----------------
   // Called at a negedge in an idle clock; returns at the negedge of the next idle clock.
   task automatic run_op(input logic [31:0] v, input int turn);
      bit          w;
      bit          noisy;
      logic [14:0] a;
      logic [7:0]  d;
      int          busy;
      logic [3:0]  st_exp, st_act;
      w = v[24]; noisy = v[25]; a = v[22:8]; d = v[7:0];
      chk(req_ready === 1'b1 && mem_dq_oe === 1'b0, "R7 idle before request",
          {30'd0, req_ready, mem_dq_oe}, 32'h2);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      busy = w ? turn + WP_C + DH_C : RD_C;
      if (busy < MIN_C) busy = MIN_C;
      for (int c = 0; c < busy; c++) begin
         @(negedge clk);
         if (noisy && c < busy - 1) begin
            req_valid = 1'b1; req_write = ~w; req_addr = ~a; req_wdata = ~d;
         end else begin
            req_valid = 1'b0;
         end
         st_act = {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe};
         if (!w)                         st_exp = 4'b0100;
         else if (c < turn)              st_exp = 4'b0110;
         else if (c < turn + WP_C)       st_exp = 4'b0011;
         else if (c < turn + WP_C + DH_C) st_exp = 4'b0111;
         else                            st_exp = 4'b1110;
         chk(st_act === st_exp,
             !w ? "R5 read strobes" : (c < turn ? "R4 turnaround clock" :
             (c < turn + WP_C ? "R2 write pulse" : "R3 data hold")),
             {28'd0, st_act}, {28'd0, st_exp});
         chk(req_ready === 1'b0 && rd_valid === 1'b0, "R7 busy ready low / R6 no valid",
             {30'd0, req_ready, rd_valid}, 32'h0);
         chk(mem_addr === a && (!w || mem_dq_out === d),
             noisy ? "R8 busy request ignored" : "R3 address and data held",
             {9'd0, mem_addr, mem_dq_out}, {9'd0, a, w ? d : mem_dq_out});
      end
      @(negedge clk);
      chk(req_ready === 1'b1 && mem_ce_n === 1'b1, "R7 ready after minimum cycle",
          {30'd0, req_ready, mem_ce_n}, 32'h3);
      if (!w)
         chk(rd_valid === 1'b1 && rd_data === d, "R6 read data returned",
             {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, d});
   endtask

   // ---------------- main sequence ----------------
   initial begin
      bit prev_rd;
      repeat (3) @(negedge clk);
      chk({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid} === 5'b11100,
          "R1 strobes during reset", {27'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid}, 32'h1C);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1 && {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe} === 4'b1110,
          "R1 idle after reset", {27'd0, req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'h1E);

      prev_rd = 1'b0;
      for (int i = 0; i < NV; i++) begin
         run_op(VEC[i], (prev_rd && VEC[i][24]) ? HZ_C - 1 : 0);
         prev_rd = !VEC[i][24];
      end

      // Directed: reset arriving inside a write pulse.
      repeat (2) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h1111; req_wdata = 8'h77;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(mem_we_n === 1'b0, "R2 pulse under way before reset", {31'd0, mem_we_n}, 32'h0);
      rst_n = 1'b0;
      @(negedge clk);
      chk({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid, req_ready} === 6'b111001,
          "R1 reset mid-write", {26'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid, req_ready},
          32'h39);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Directed: read-back after reset still reaches the stored byte at the top address.
      run_op(32'h007FFF3C, 0);

      chk(cont_err == 0, "R4 no bus contention seen", cont_err, 0);
      chk(addr_err == 0, "R3 address stable under write enable", addr_err, 0);

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule